// File: doc/BRIEF.md
# Four-State Channel Drive Decoder with Break-Before-Make Gap

This block sits between a per-channel data latch and the level shifters of a bank of high-voltage output stages. For every channel it combines the latched data bit with four shared controls (positive select, negative select, float, clear) into one of four drive states: positive rail, negative rail, ground, or high impedance. Each state is presented as three one-hot-or-zero enable lines per channel. High impedance is the state where all three lines are low.

A change in a channel's commanded state never reaches the enables directly. The channel first floats for `DEAD` clock cycles and then takes up its new state. If another command change arrives during that gap, the gap starts again. Commanded high impedance is the exception: it is applied at the next clock edge with no gap.

Top module: `hv_state_decoder`

## Requirements
- R1: While `float_in` is high at a clock edge, every channel shows high impedance (all three enables low) after that edge, whatever the other inputs are, and with no gap.
- R2: With `float_in` low and `clear_in` high, every channel's command is ground. The ground enable is reached after the gap of R7.
- R3: With `float_in` and `clear_in` low, a channel whose latched bit is 0, or any channel while both selects are low, is commanded to ground.
- R4: With both selects high, `float_in` low and `clear_in` low, a channel whose latched bit is 1 is commanded to high impedance, with no gap.
- R5: Positive select high, negative select low and latched bit 1 (with `float_in` and `clear_in` low) command the positive-rail enable `rail_p_en`.
- R6: Negative select high, positive select low and latched bit 1 (with `float_in` and `clear_in` low) command the negative-rail enable `rail_n_en`.
- R7: When a channel's command changes at edge k to a driven state, the channel shows high impedance after edges k through k+DEAD-1 and shows the new state from edge k+DEAD on.
- R8: A command change at an edge during a channel's gap restarts the gap at that edge, as R7 describes.
- R9: Per channel, at most one of `rail_p_en`, `rail_n_en` and `gnd_en` is high in any cycle. A channel never moves from one driven state to a different driven state between adjacent cycles.
- R10: While `rst_n` is low, and after it is released until the first command change, every channel drives ground (`gnd_en` high) with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| latch_q | input | CH | Latched data bit per channel |
| sel_pos | input | 1 | Positive-rail select |
| sel_neg | input | 1 | Negative-rail select |
| float_in | input | 1 | Forces every channel to high impedance |
| clear_in | input | 1 | Sends every channel to ground |
| rail_p_en | output | CH | Per-channel positive-rail enable |
| rail_n_en | output | CH | Per-channel negative-rail enable |
| gnd_en | output | CH | Per-channel ground enable |

## Verification
The gap countdown and a fresh command can land in the same cycle. This happens when a channel's count reaches its last step in the very cycle that a select, clear or float change arrives. The command must win: the gap restarts, or the channel floats at once, and the stale target must not be released. The bench provokes this with directed sequences that change the command part-way through a gap and exactly one cycle before it ends. It adds random commands with random hold lengths around `DEAD`, and checks every channel in every cycle against a cycle-level model built from the requirements.

// File: rtl/hv_state_decoder.sv
module hv_state_decoder #(
  parameter int CH   = 32,
  parameter int DEAD = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CH-1:0] latch_q,
  input  logic          sel_pos,
  input  logic          sel_neg,
  input  logic          float_in,
  input  logic          clear_in,
  output logic [CH-1:0] rail_p_en,
  output logic [CH-1:0] rail_n_en,
  output logic [CH-1:0] gnd_en
);
  localparam int CW = $clog2(DEAD + 1);
  localparam logic [CW-1:0] GAP = CW'(DEAD);

  typedef enum logic [1:0] {ST_Z, ST_P, ST_N, ST_G} drv_t;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    drv_t want, tgt_q, cur;
    logic [CW-1:0] cnt;

    always_comb begin
      if (float_in)                     want = ST_Z;
      else if (clear_in || !latch_q[i]) want = ST_G;
      else if (sel_pos && sel_neg)      want = ST_Z;
      else if (sel_pos)                 want = ST_P;
      else if (sel_neg)                 want = ST_N;
      else                              want = ST_G;
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tgt_q <= ST_G;
        cur   <= ST_G;
        cnt   <= '0;
      end else if (want != tgt_q) begin
        tgt_q <= want;
        cur   <= ST_Z;
        cnt   <= (want == ST_Z) ? '0 : GAP;
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
        if (cnt == CW'(1)) cur <= tgt_q;
      end
    end

    assign rail_p_en[i] = (cur == ST_P);
    assign rail_n_en[i] = (cur == ST_N);
    assign gnd_en[i]    = (cur == ST_G);

    assert_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rail_p_en[i], rail_n_en[i], gnd_en[i]}));

    assert_bbm_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rail_p_en[i] || rail_n_en[i] || gnd_en[i]) |=>
        (!(rail_p_en[i] || rail_n_en[i] || gnd_en[i]) ||
         (rail_p_en[i] == $past(rail_p_en[i]) && rail_n_en[i] == $past(rail_n_en[i]))));

    assert_pos_cmd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rail_p_en[i]) && rail_p_en[i] |->
        $past(sel_pos && !sel_neg && latch_q[i] && !float_in && !clear_in));

    assert_neg_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(rail_n_en[i]) && rail_n_en[i] |->
        $past(sel_neg && !sel_pos && latch_q[i] && !float_in && !clear_in));
  end

  assert_float_R1: assert property (@(posedge clk) disable iff (!rst_n)
    float_in |=> (rail_p_en == '0 && rail_n_en == '0 && gnd_en == '0));

  assert_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear_in && !float_in |=> (rail_p_en == '0 && rail_n_en == '0));

  initial assert (DEAD >= 1) else $error("DEAD must be at least 1");
endmodule

// File: tb/hv_state_decoder_test.sv
module hv_state_decoder_test;
  localparam int CH = 32;
  localparam int DEAD = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [CH-1:0] latch_q = '0;
  logic sel_pos = 0, sel_neg = 0, float_in = 0, clear_in = 0;
  logic [CH-1:0] rail_p_en, rail_n_en, gnd_en;

  int checks = 0, errors = 0;
  bit done = 0;

  int m_tgt [CH];
  int m_out [CH];
  int m_cnt [CH];

  always #4 clk = ~clk;

  hv_state_decoder #(.CH(CH), .DEAD(DEAD)) uut (
    .clk(clk), .rst_n(rst_n), .latch_q(latch_q), .sel_pos(sel_pos), .sel_neg(sel_neg),
    .float_in(float_in), .clear_in(clear_in),
    .rail_p_en(rail_p_en), .rail_n_en(rail_n_en), .gnd_en(gnd_en));

  // 0 = high impedance, 1 = positive, 2 = negative, 3 = ground
  function automatic int cmd_of(bit d);
    if (float_in) return 0;
    if (clear_in || !d) return 3;
    if (sel_pos && sel_neg) return 0;
    if (sel_pos) return 1;
    if (sel_neg) return 2;
    return 3;
  endfunction

  function automatic logic [2:0] enc(int s);
    return {s == 1, s == 2, s == 3};
  endfunction

  task automatic tick(string tag);
    @(posedge clk);
    for (int i = 0; i < CH; i++) begin
      if (!rst_n) begin
        m_tgt[i] = 3; m_out[i] = 3; m_cnt[i] = 0;
      end else begin
        int w = cmd_of(latch_q[i]);
        if (w != m_tgt[i]) begin
          m_tgt[i] = w; m_out[i] = 0; m_cnt[i] = (w == 0) ? 0 : DEAD;
        end else if (m_cnt[i] != 0) begin
          if (m_cnt[i] == 1) m_out[i] = m_tgt[i];
          m_cnt[i]--;
        end
      end
    end
    @(negedge clk);
    begin
      logic [CH-1:0] ep, en, eg;
      for (int i = 0; i < CH; i++) {ep[i], en[i], eg[i]} = enc(m_out[i]);
      checks++;
      if (rail_p_en !== ep || rail_n_en !== en || gnd_en !== eg) begin
        errors++;
        $display("FAIL %s p/n/g act %h/%h/%h exp %h/%h/%h", tag,
                 rail_p_en, rail_n_en, gnd_en, ep, en, eg);
      end
      checks++;
      if (((rail_p_en & rail_n_en) | (rail_p_en & gnd_en) | (rail_n_en & gnd_en)) !== '0) begin
        errors++;
        $display("FAIL R9 overlap act %h/%h/%h exp no overlap", rail_p_en, rail_n_en, gnd_en);
      end
    end
  endtask

  task automatic hold(int n, string tag);
    for (int k = 0; k < n; k++) tick(tag);
  endtask

  task automatic drive(bit p, bit n, bit f, bit c);
    sel_pos = p; sel_neg = n; float_in = f; clear_in = c;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act hung exp finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    hold(3, "R10 reset");
    rst_n = 1'b1;
    hold(4, "R10 after reset");

    latch_q = 32'hA5C3_0F69;
    drive(1, 0, 0, 0); hold(DEAD + 6, "R5 R7 positive");
    drive(0, 1, 0, 0); hold(DEAD + 6, "R6 R7 negative");
    drive(1, 1, 0, 0); hold(6, "R4 both selects");
    drive(0, 0, 0, 0); hold(DEAD + 4, "R3 selects low");
    drive(1, 0, 0, 0); hold(5, "R7 gap start");
    drive(1, 0, 1, 0); hold(4, "R1 float mid gap");
    drive(1, 0, 0, 0); hold(DEAD + 3, "R7 after float");
    drive(1, 0, 1, 0); hold(3, "R1 float on driven");
    drive(0, 1, 0, 1); hold(DEAD + 3, "R2 clear");
    drive(0, 1, 0, 0); hold(5, "R8 gap partly run");
    drive(1, 0, 0, 0); hold(DEAD - 1, "R8 restart");
    drive(0, 1, 0, 0); hold(DEAD + 3, "R8 restart at last step");
    latch_q = ~latch_q; hold(DEAD + 3, "R3 R7 data flip");

    for (int r = 0; r < 300; r++) begin
      int len = 1 + ($urandom % (DEAD + 8));
      if ($urandom % 4 == 0) latch_q = $urandom;
      drive(1'($urandom), 1'($urandom), ($urandom % 8) == 0, ($urandom % 8) == 0);
      hold(len, "R7 R9 random");
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule